// File: doc/BRIEF.md
# Nibble-Clustered Zero-Gated Multiplier

This block multiplies two unsigned operands of `W` bits and gives a `2W`-bit product. Each operand is cut into 4-bit slices. Every pairing of one slice of `a_in` with one slice of `b_in` gets its own 4x4 cluster, which has an 8-bit result register. The top sums the cluster results, each shifted left by four times the sum of its two slice indices, to form the full product.

A cluster whose `a` slice or `b` slice is all zero keeps its register enable low for that operation. Its register does not toggle, and it adds nothing to the sum. Register enables stand in for clock gating, so gating never changes the result. An activity output reports how many clusters were enabled for the most recent operation, which makes the gating visible at the ports.

Operands are captured on a cycle with `in_valid` high. The result appears with `out_valid` two rising edges later, whatever the gating pattern, and a new operation may start on every cycle.

Top module: `nibble_cluster_mul`

## Requirements
- R1: When `out_valid` is high, `product` equals the unsigned product of the operands accepted two edges earlier, zero-extended to `2W` bits (default `W`=16).
- R2: An operand pair sampled with `in_valid` high at rising edge k gives `out_valid` high for exactly the cycle after edge k+1. `out_valid` is low in all other cycles. The latency does not depend on the operand values.
- R3: For each operation, `active_count` equals the number of nonzero 4-bit slices of `a` times the number of nonzero 4-bit slices of `b`. Slice i is bits [4i+3:4i]. This count is never more than (W/4)^2.
- R4: If either operand is zero, the result has `product` = 0 and `active_count` = 0.
- R5: In cycles where `out_valid` is low, `product` and `active_count` hold their last values, even when `a_in` and `b_in` change while `in_valid` is low.
- R6: After synchronous active-low reset, `out_valid`, `product` and `active_count` are all 0.
- R7: Operations issued on consecutive cycles give results on consecutive cycles, in issue order, each with its own correct product and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands on `a_in`/`b_in` are accepted this cycle |
| a_in | input | W | Unsigned operand A |
| b_in | input | W | Unsigned operand B |
| out_valid | output | 1 | Result is valid this cycle |
| product | output | 2W | Unsigned product |
| active_count | output | clog2((W/4)^2+1) | Clusters enabled for the most recent operation |

## Verification
Several behaviours are checked by assertions on every cycle:
- the fixed two-edge latency;
- that outputs hold between results;
- the product against a reference multiply of the accepted operands, carried two stages along;
- the enable count against the product of the two nonzero-slice counts;
- a zero product whenever no cluster fired.

Other behaviours need the bench's scenarios to show them:
- reset values;
- results issued back to back in order;
- outputs that stay unchanged while the idle operands toggle;
- boundary patterns: all-ones, single-slice, and all-zero operands.

// File: rtl/nibble_cluster_mul.sv
module nibble_cluster_mul #(
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [W-1:0]         a_in,
  input  logic [W-1:0]         b_in,
  output logic                 out_valid,
  output logic [2*W-1:0]       product,
  output logic [$clog2((W/4)*(W/4)+1)-1:0] active_count
);
  localparam int N  = W / 4;
  localparam int NC = N * N;
  localparam int PW = 2 * W;
  localparam int CW = $clog2(NC + 1);

  logic [W-1:0] a_q, b_q;
  logic         v1, v2;
  logic [NC-1:0] en, live;
  logic [7:0]   prod [NC];
  logic [7:0]   pp   [NC];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      v1  <= 1'b0;
      v2  <= 1'b0;
    end else begin
      v1 <= in_valid;
      v2 <= v1;
      if (in_valid) begin
        a_q <= a_in;
        b_q <= b_in;
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_a
    for (genvar j = 0; j < N; j++) begin : g_b
      assign en[i*N+j]   = v1 & (|a_q[4*i +: 4]) & (|b_q[4*j +: 4]);
      assign prod[i*N+j] = {4'b0, a_q[4*i +: 4]} * {4'b0, b_q[4*j +: 4]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live <= '0;
      for (int k = 0; k < NC; k++) pp[k] <= '0;
    end else begin
      if (v1) live <= en;
      for (int k = 0; k < NC; k++)
        if (en[k]) pp[k] <= prod[k];
    end
  end

  always_comb begin
    product      = '0;
    active_count = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (live[i*N+j]) begin
          product      = product + (PW'(pp[i*N+j]) << (4*(i+j)));
          active_count = active_count + CW'(1);
        end
  end

  assign out_valid = v2;
endmodule

// File: rtl/nibble_cluster_mul_chk.sv
module nibble_cluster_mul_chk #(
  parameter int W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [W-1:0]         a_in,
  input logic [W-1:0]         b_in,
  input logic                 out_valid,
  input logic [2*W-1:0]       product,
  input logic [$clog2((W/4)*(W/4)+1)-1:0] active_count
);
  localparam int N  = W / 4;
  localparam int PW = 2 * W;
  localparam int CW = $clog2(N * N + 1);

  logic [W-1:0] ra1, rb1, ra2, rb2;
  logic         rv1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ra1 <= '0; rb1 <= '0; ra2 <= '0; rb2 <= '0; rv1 <= 1'b0;
    end else begin
      rv1 <= in_valid;
      if (in_valid) begin ra1 <= a_in; rb1 <= b_in; end
      if (rv1) begin ra2 <= ra1; rb2 <= rb1; end
    end
  end

  function automatic int nz(input logic [W-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) if (v[4*i +: 4] != 4'd0) c++;
    return c;
  endfunction

  logic [PW-1:0] ref_p;
  logic [CW-1:0] ref_c;
  assign ref_p = PW'(ra2) * PW'(rb2);
  assign ref_c = CW'(nz(ra2) * nz(rb2));

  assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> product == ref_p);
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);
  assert_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> active_count == ref_c);
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(active_count) <= N * N);
  assert_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && active_count == '0) |-> product == '0);
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(product) && $stable(active_count)));
endmodule

bind nibble_cluster_mul nibble_cluster_mul_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_in(a_in), .b_in(b_in),
  .out_valid(out_valid), .product(product), .active_count(active_count)
);

// File: tb/tb_nibble_cluster_mul.sv
module tb_nibble_cluster_mul;
  localparam int W  = 16;
  localparam int N  = W / 4;
  localparam int PW = 2 * W;
  localparam int CW = $clog2(N * N + 1);
  localparam int NV = 14;
  localparam logic [2*W-1:0] VEC [NV] = '{
    {16'h0000, 16'h1234}, {16'hFFFF, 16'hFFFF}, {16'h0001, 16'h0001},
    {16'h1000, 16'h0100}, {16'hF00F, 16'h0F0F}, {16'h7676, 16'h6363},
    {16'h0000, 16'h0000}, {16'h8000, 16'h8000}, {16'hABCD, 16'h0000},
    {16'h1111, 16'hFFFF}, {16'h0F00, 16'hF0F0}, {16'hFFFF, 16'h0001},
    {16'h0080, 16'h0800}, {16'h9D9D, 16'h8A8A}
  };

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic out_valid;
  logic [PW-1:0] product;
  logic [CW-1:0] active_count;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  nibble_cluster_mul #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_in(a_in), .b_in(b_in),
    .out_valid(out_valid), .product(product), .active_count(active_count)
  );

  function automatic int nzc(input logic [W-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) if (v[4*i +: 4] != 4'd0) c++;
    return c;
  endfunction

  task automatic chk(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_result(input string req, input logic [W-1:0] a, input logic [W-1:0] b);
    chk({req, " R2 valid"}, PW'(out_valid), PW'(1));
    chk({req, " R1 product"}, product, PW'(a) * PW'(b));
    chk({req, " R3 count"}, PW'(active_count), PW'(nzc(a) * nzc(b)));
  endtask

  task automatic one_op(input string req, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk); a_in = a; b_in = b; in_valid = 1;
    @(negedge clk); in_valid = 0;
    chk({req, " R2 early"}, PW'(out_valid), PW'(0));
    @(negedge clk);
    check_result(req, a, b);
    @(negedge clk);
    chk({req, " R2 pulse"}, PW'(out_valid), PW'(0));
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [W-1:0] ba [6];
    logic [W-1:0] bb [6];
    logic [PW-1:0] hp;
    logic [CW-1:0] hc;
    logic [31:0] lfsr = 32'h1ACE_B00C;
    repeat (3) @(negedge clk);
    // R6 reset state
    chk("R6 valid", PW'(out_valid), PW'(0));
    chk("R6 product", product, PW'(0));
    chk("R6 count", PW'(active_count), PW'(0));
    rst_n = 1;

    for (int v = 0; v < NV; v++)
      one_op("R1 R3 R4 table", VEC[v][2*W-1:W], VEC[v][W-1:0]);

    for (int r = 0; r < 20; r++) begin
      logic [W-1:0] ra, rb;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      ra = lfsr[31:16];
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      rb = lfsr[31:16];
      if (r % 3 == 0) ra = ra & 16'hF0F0;
      if (r % 4 == 1) rb = rb & 16'h000F;
      one_op("R1 R3 random", ra, rb);
    end

    // R4 zero operand
    one_op("R4 a zero", 16'h0000, 16'hBEEF);
    chk("R4 zero product", product, PW'(0));
    chk("R4 zero count", PW'(active_count), PW'(0));

    // R5 hold while idle inputs change
    one_op("R5 setup", 16'h1234, 16'h5678);
    hp = product; hc = active_count;
    for (int t = 0; t < 4; t++) begin
      @(negedge clk); a_in = 16'hFFFF - W'(t); b_in = 16'h0F0F + W'(t);
      chk("R5 no valid", PW'(out_valid), PW'(0));
      chk("R5 product hold", product, hp);
      chk("R5 count hold", PW'(active_count), PW'(hc));
    end

    // R7 back-to-back
    ba = '{16'h0003, 16'hFFFF, 16'h0000, 16'hA000, 16'h1F2E, 16'h0101};
    bb = '{16'h0005, 16'h00FF, 16'h1111, 16'h000A, 16'h3C4D, 16'hFFFF};
    for (int t = 0; t < 8; t++) begin
      @(negedge clk);
      if (t >= 2) check_result("R7 stream", ba[t-2], bb[t-2]);
      if (t < 6) begin a_in = ba[t]; b_in = bb[t]; in_valid = 1; end
      else in_valid = 0;
    end
    @(negedge clk);
    chk("R7 stream end", PW'(out_valid), PW'(0));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule